// File: doc/BRIEF.md
# Serial Flash Page-Program Write Buffer

This block is the write side of a serial-flash controller. Software puts a shared 128-byte buffer into page-program mode and loads a flash address. It then pushes the page as 32 little-endian 32-bit words through one data port and writes a program command. The block sends the whole page as a single page-program transaction on a one-lane SPI bus in mode 0, and clears the command field once chip select goes high again.

Tails shorter than a page use a second path. After buffer mode is switched off, software places one byte in a data register and issues a single-byte command. The block then sends a one-byte program frame and advances the flash address by one, so that back-to-back single-byte writes land on consecutive locations.

Register access is a simple synchronous write strobe with a byte address. Read data is combinational from the address.

Top module: `flash_pgm_wbuf`

## Requirements
- R1: After reset `cs_n_o` is 1, `sck_o` is 0, and the command register (offset 0x00) and the mode register (offset 0x04) both read 0.
- R2: Bit 0 of the mode register requests page-program mode (1) or read-prefetch mode (0). A request written while idle takes effect by the second clock edge. A request written during a command is held back until that command ends. The register always reads the mode currently in effect.
- R3: The page data port (offset 0x18) fills the buffer one 32-bit word per write. Page byte k comes from word k/4, bits 8*(k mod 4)+7 down to 8*(k mod 4), so word bits 7:0 hold the lowest-addressed byte.
- R4: Writing 0x10 to the command register in page-program mode sends, under one low period of `cs_n_o`, the byte 0x02, then address bits 23:16, 15:8 and 7:0, then buffer bytes 0 to 127 in order. Each byte goes MSB first, with `mosi_o` valid on the rising edge of `sck_o`, and `sck_o` stays low whenever `cs_n_o` is high.
- R5: While a command runs, the command register reads back its code. It reads 0 from the cycle `cs_n_o` returns high.
- R6: The address bytes are written from data bits 7:0: bits 7:0 at 0x08, bits 15:8 at 0x0C, bits 23:16 at 0x10 and bits 31:24 at 0x20. Each address register reads back its byte in bits 7:0.
- R7: The buffer write pointer returns to word 0 when page-program mode takes effect and when a page program completes. Data-port writes after the 32nd word are dropped.
- R8: Writing 0x90 to the command register in read-prefetch mode sends the byte 0x02, the three address bytes (bits 23:16 first) and the byte held at offset 0x14. In page-program mode 0x90 is ignored.
- R9: Each completed single-byte write increments the 32-bit address by one, carrying across bytes.
- R10: While a command runs, command writes and address writes are ignored. A 0x10 command in read-prefetch mode is ignored.
- R11: A command code other than 0x10 or 0x90 starts no transaction and leaves the command register at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| sck_o | output | 1 | SPI clock, idle low |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI serial data to the flash |

## Verification
Two functions can meet in the same cycle: a change of buffer mode and a page program that is still shifting. The bench writes read-prefetch mode, a second program command and a new address byte partway through a page frame. It then reads the mode register while the frame is still running and expects page-program mode to persist. After completion it expects read-prefetch mode, the old address, exactly one frame and a page byte stream that is unchanged.

// File: rtl/flash_wbuf_pkg.sv
package flash_wbuf_pkg;
  localparam int REG_AW    = 8;
  localparam int HDR_BYTES = 4;

  localparam logic [REG_AW-1:0] OFF_CMD   = 8'h00;
  localparam logic [REG_AW-1:0] OFF_MODE  = 8'h04;
  localparam logic [REG_AW-1:0] OFF_ADR0  = 8'h08;
  localparam logic [REG_AW-1:0] OFF_ADR1  = 8'h0C;
  localparam logic [REG_AW-1:0] OFF_ADR2  = 8'h10;
  localparam logic [REG_AW-1:0] OFF_WBYTE = 8'h14;
  localparam logic [REG_AW-1:0] OFF_PAGE  = 8'h18;
  localparam logic [REG_AW-1:0] OFF_ADR3  = 8'h20;

  localparam logic [7:0] CMD_IDLE = 8'h00;
  localparam logic [7:0] CMD_PAGE = 8'h10;
  localparam logic [7:0] CMD_PIO  = 8'h90;
  localparam logic [7:0] OP_PROG  = 8'h02;
endpackage

// File: rtl/flash_wbuf_mem.sv
module flash_wbuf_mem #(
  parameter int BUF_BYTES = 128,
  localparam int WORDS = BUF_BYTES / 4,
  localparam int PTR_W = $clog2(WORDS + 1),
  localparam int BI_W  = $clog2(BUF_BYTES),
  localparam int WI_W  = BI_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic [BI_W-1:0]  byte_idx_i,
  output logic [7:0]       byte_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic [31:0]      mem_q [WORDS];
  logic [PTR_W-1:0] ptr_q;
  logic             push;
  logic [31:0]      rd_word;

  assign push = wr_i && !clr_i && (ptr_q < PTR_W'(WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (push)  ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[ptr_q[WI_W-1:0]] <= wdata_i;
  end

  // little-endian lane select
  assign rd_word = mem_q[byte_idx_i[BI_W-1:2]];
  assign byte_o  = rd_word[8*byte_idx_i[1:0] +: 8];
  assign ptr_o   = ptr_q;
endmodule

// File: rtl/flash_pgm_seq.sv
module flash_pgm_seq
  import flash_wbuf_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  localparam int IDX_W = $clog2(BUF_BYTES + HDR_BYTES + 1),
  localparam int BI_W  = $clog2(BUF_BYTES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            done_i,
  input  logic            page_i,
  input  logic [23:0]     addr_i,
  input  logic [7:0]      wbyte_i,
  input  logic [7:0]      buf_byte_i,
  output logic [7:0]      byte_o,
  output logic            more_o,
  output logic [BI_W-1:0] buf_idx_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (done_i) idx_q <= '0;
    else if (take_i) idx_q <= idx_q + 1'b1;
  end

  assign last      = page_i ? IDX_W'(HDR_BYTES + BUF_BYTES) : IDX_W'(HDR_BYTES + 1);
  assign more_o    = idx_q < last;
  assign buf_idx_o = BI_W'(idx_q - IDX_W'(HDR_BYTES));

  always_comb begin
    case (idx_q)
      IDX_W'(0): byte_o = OP_PROG;
      IDX_W'(1): byte_o = addr_i[23:16];
      IDX_W'(2): byte_o = addr_i[15:8];
      IDX_W'(3): byte_o = addr_i[7:0];
      default:   byte_o = page_i ? buf_byte_i : wbyte_i;
    endcase
  end
endmodule

// File: rtl/flash_spi_shift.sv
module flash_spi_shift #(
  parameter int SCK_HALF = 2,
  localparam int DIV_W = $clog2(SCK_HALF + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       more_i,
  output logic       take_o,
  output logic       done_o,
  output logic       sck_o,
  output logic       cs_n_o,
  output logic       mosi_o
);
  logic             active_q, sck_q, cs_n_q;
  logic [7:0]       sr_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic             launch, tick, byte_end;

  assign launch   = start_i && !active_q;
  assign tick     = active_q && (div_q == DIV_W'(SCK_HALF - 1));
  assign byte_end = tick && sck_q && (bit_q == 3'd7);
  assign take_o   = launch || (byte_end && more_i);
  assign done_o   = byte_end && !more_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      cs_n_q   <= 1'b1;
      sr_q     <= '0;
      bit_q    <= '0;
      div_q    <= '0;
    end else if (launch) begin
      active_q <= 1'b1;
      cs_n_q   <= 1'b0;
      sck_q    <= 1'b0;
      sr_q     <= byte_i;
      bit_q    <= '0;
      div_q    <= '0;
    end else if (active_q) begin
      if (tick) begin
        div_q <= '0;
        if (!sck_q) begin
          sck_q <= 1'b1;
        end else begin
          sck_q <= 1'b0;
          if (bit_q == 3'd7) begin
            if (more_i) begin
              sr_q  <= byte_i;
              bit_q <= '0;
            end else begin
              active_q <= 1'b0;
              cs_n_q   <= 1'b1;
            end
          end else begin
            sr_q  <= {sr_q[6:0], 1'b0};
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign sck_o  = sck_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = sr_q[7];
endmodule

// File: rtl/flash_pgm_wbuf.sv
module flash_pgm_wbuf
  import flash_wbuf_pkg::*;
#(
  parameter int BUF_BYTES = 128,
  parameter int SCK_HALF  = 2,
  localparam int WORDS = BUF_BYTES / 4,
  localparam int PTR_W = $clog2(WORDS + 1),
  localparam int BI_W  = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              sck_o,
  output logic              cs_n_o,
  output logic              mosi_o
);
  logic [7:0]       cmd_q;
  logic             mode_req_q, mode_eff_q;
  logic [31:0]      addr_q;
  logic [7:0]       wbyte_q;

  logic             idle, busy, start_page, start_pio, start;
  logic             sh_take, sh_done, sh_more, page_done, pio_done;
  logic             buf_clr, page_wr, wr_idle;
  logic [7:0]       sh_byte, buf_byte;
  logic [BI_W-1:0]  buf_idx;
  logic [PTR_W-1:0] wptr;

  assign idle       = (cmd_q == CMD_IDLE);
  assign busy       = !idle;
  assign wr_idle    = reg_wr_i && idle;
  assign start_page = wr_idle && (reg_addr_i == OFF_CMD) && (reg_wdata_i[7:0] == CMD_PAGE) && mode_eff_q;
  assign start_pio  = wr_idle && (reg_addr_i == OFF_CMD) && (reg_wdata_i[7:0] == CMD_PIO) && !mode_eff_q;
  assign start      = start_page || start_pio;
  assign page_done  = sh_done && (cmd_q == CMD_PAGE);
  assign pio_done   = sh_done && (cmd_q == CMD_PIO);
  assign buf_clr    = (idle && !start && mode_req_q && !mode_eff_q) || page_done;
  assign page_wr    = wr_idle && (reg_addr_i == OFF_PAGE) && mode_eff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q      <= CMD_IDLE;
      mode_req_q <= 1'b0;
      mode_eff_q <= 1'b0;
      addr_q     <= '0;
      wbyte_q    <= '0;
    end else begin
      if (start)        cmd_q <= reg_wdata_i[7:0];
      else if (sh_done) cmd_q <= CMD_IDLE;

      if (reg_wr_i && reg_addr_i == OFF_MODE) mode_req_q <= reg_wdata_i[0];
      // mode swaps only between commands
      if (idle && !start) mode_eff_q <= mode_req_q;

      if (pio_done) begin
        addr_q <= addr_q + 32'd1;
      end else if (wr_idle) begin
        case (reg_addr_i)
          OFF_ADR0: addr_q[7:0]   <= reg_wdata_i[7:0];
          OFF_ADR1: addr_q[15:8]  <= reg_wdata_i[7:0];
          OFF_ADR2: addr_q[23:16] <= reg_wdata_i[7:0];
          OFF_ADR3: addr_q[31:24] <= reg_wdata_i[7:0];
          default: ;
        endcase
      end

      if (wr_idle && reg_addr_i == OFF_WBYTE) wbyte_q <= reg_wdata_i[7:0];
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFF_CMD:   reg_rdata_o = {24'd0, cmd_q};
      OFF_MODE:  reg_rdata_o = {31'd0, mode_eff_q};
      OFF_ADR0:  reg_rdata_o = {24'd0, addr_q[7:0]};
      OFF_ADR1:  reg_rdata_o = {24'd0, addr_q[15:8]};
      OFF_ADR2:  reg_rdata_o = {24'd0, addr_q[23:16]};
      OFF_ADR3:  reg_rdata_o = {24'd0, addr_q[31:24]};
      OFF_WBYTE: reg_rdata_o = {24'd0, wbyte_q};
      default:   reg_rdata_o = 32'd0;
    endcase
  end

  flash_wbuf_mem #(.BUF_BYTES(BUF_BYTES)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .wr_i       (page_wr),
    .wdata_i    (reg_wdata_i),
    .byte_idx_i (buf_idx),
    .byte_o     (buf_byte),
    .ptr_o      (wptr)
  );

  flash_pgm_seq #(.BUF_BYTES(BUF_BYTES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (sh_take),
    .done_i     (sh_done),
    .page_i     (cmd_q == CMD_PAGE),
    .addr_i     (addr_q[23:0]),
    .wbyte_i    (wbyte_q),
    .buf_byte_i (buf_byte),
    .byte_o     (sh_byte),
    .more_o     (sh_more),
    .buf_idx_o  (buf_idx)
  );

  flash_spi_shift #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .byte_i  (sh_byte),
    .more_i  (sh_more),
    .take_o  (sh_take),
    .done_o  (sh_done),
    .sck_o   (sck_o),
    .cs_n_o  (cs_n_o),
    .mosi_o  (mosi_o)
  );
endmodule

// File: rtl/flash_pgm_wbuf_chk.sv
module flash_pgm_wbuf_chk #(
  parameter int WORDS = 32,
  parameter int PTR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic             sck_i,
  input logic             busy_i,
  input logic             mode_i,
  input logic [PTR_W-1:0] ptr_i
);
  // R4
  sck_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_i) |-> !cs_n_i);
  // R4
  sck_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !sck_i);
  // R5
  cs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_i) |-> busy_i);
  // R5
  done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_n_i) |-> !busy_i);
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(mode_i));
  // R7
  ptr_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_i <= PTR_W'(WORDS));
endmodule

bind flash_pgm_wbuf flash_pgm_wbuf_chk #(.WORDS(WORDS), .PTR_W(PTR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_n_i (cs_n_o),
  .sck_i  (sck_o),
  .busy_i (busy),
  .mode_i (mode_eff_q),
  .ptr_i  (wptr)
);

// File: tb/flash_pgm_wbuf_tb_top.sv
module flash_pgm_wbuf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, cs_n, mosi;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pgm_wbuf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck), .cs_n_o(cs_n), .mosi_o(mosi)
  );

  // flash-side capture
  logic [7:0] rx [0:255];
  logic [7:0] sh = '0;
  int rxn = 0, bitc = 0, frames = 0;
  logic [7:0] expb [0:255];

  always @(negedge cs_n) begin rxn = 0; bitc = 0; end
  always @(posedge cs_n) frames = frames + 1;
  always @(posedge sck) if (!cs_n) begin
    sh = {sh[6:0], mosi};
    bitc = bitc + 1;
    if (bitc % 8 == 0) begin
      if (rxn < 256) rx[rxn] = sh;
      rxn = rxn + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_mode(input logic m);
    reg_wr(8'h04, {31'd0, m});
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(8'h00, v);
      if (v == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic set_addr(input logic [31:0] a);
    reg_wr(8'h08, {24'd0, a[7:0]});
    reg_wr(8'h0C, {24'd0, a[15:8]});
    reg_wr(8'h10, {24'd0, a[23:16]});
    reg_wr(8'h20, {24'd0, a[31:24]});
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((k * 13 + seed * 29 + 5) & 255);
  endfunction

  task automatic fill_page(input int seed, input int nwords);
    for (int w = 0; w < nwords; w++)
      reg_wr(8'h18, {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
  endtask

  task automatic cmp_frame(input string tag, input int n);
    int bad = 0;
    chk({tag, " frame length"}, rxn, n);
    for (int i = 0; i < n; i++) if (rx[i] !== expb[i]) begin
      if (bad < 4) $display("FAIL %s byte %0d actual=%0h expected=%0h", tag, i, rx[i], expb[i]);
      bad++;
    end
    n_chk++;
    if (bad != 0) n_bad++;
  endtask

  task automatic exp_page(input logic [31:0] a, input int seed);
    expb[0] = 8'h02; expb[1] = a[23:16]; expb[2] = a[15:8]; expb[3] = a[7:0];
    for (int k = 0; k < 128; k++) expb[4+k] = pat(seed, k);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 cs_n", {31'd0, cs_n}, 1);
    chk("R1 sck", {31'd0, sck}, 0);
    reg_rd(8'h00, v); chk("R1 cmd", v, 0);
    reg_rd(8'h04, v); chk("R1 mode", v, 0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    set_addr(32'hC3_A1_B2_D4);
    reg_rd(8'h08, v); chk("R6 addr0", v, 32'hD4);
    reg_rd(8'h0C, v); chk("R6 addr1", v, 32'hB2);
    reg_rd(8'h10, v); chk("R6 addr2", v, 32'hA1);
    reg_rd(8'h20, v); chk("R6 addr3", v, 32'hC3);
  endtask

  // page program with mode change, extra command and address write during the frame
  task automatic t_page_overlap();
    logic [31:0] v;
    int f0;
    set_mode(1'b1);
    reg_rd(8'h04, v); chk("R2 mode on", v, 1);
    set_addr(32'h00_44_55_66);
    fill_page(1, 32);
    reg_wr(8'h18, 32'hDEAD_BEEF);   // 33rd word dropped (R7)
    f0 = frames;
    reg_wr(8'h00, 32'h10);
    reg_rd(8'h00, v); chk("R5 cmd busy", v, 32'h10);
    reg_wr(8'h04, 32'h0);
    reg_wr(8'h00, 32'h10);          // R10 ignored while busy
    reg_wr(8'h08, 32'h99);          // R10 ignored while busy
    repeat (20) @(negedge clk);
    reg_rd(8'h04, v); chk("R2 mode held during busy", v, 1);
    wait_idle();
    reg_rd(8'h00, v); chk("R5 cmd cleared", v, 0);
    reg_rd(8'h04, v); chk("R2 mode after busy", v, 0);
    reg_rd(8'h08, v); chk("R10 addr0 unchanged", v, 32'h66);
    chk("R4 one frame", frames - f0, 1);
    exp_page(32'h00_44_55_66, 1);
    cmp_frame("R3 R4 R7 page", 132);
  endtask

  task automatic t_ptr_reset();
    int f0;
    set_mode(1'b1);
    set_addr(32'h00_01_02_00);
    fill_page(2, 32);
    reg_wr(8'h00, 32'h10);
    wait_idle();
    fill_page(3, 32);               // R7 pointer reset after program
    f0 = frames;
    reg_wr(8'h00, 32'h10);
    wait_idle();
    chk("R7 frame count", frames - f0, 1);
    exp_page(32'h00_01_02_00, 3);
    cmp_frame("R7 second page", 132);
    fill_page(4, 5);
    set_mode(1'b0);
    set_mode(1'b1);                 // R7 pointer reset on entry
    fill_page(5, 32);
    reg_wr(8'h00, 32'h10);
    wait_idle();
    exp_page(32'h00_01_02_00, 5);
    cmp_frame("R7 after re-entry", 132);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    int f0;
    set_mode(1'b1);
    f0 = frames;
    reg_wr(8'h00, 32'h90);          // R8 ignored in page mode
    repeat (30) @(negedge clk);
    chk("R8 pio ignored in page mode", frames - f0, 0);
    reg_rd(8'h00, v); chk("R8 cmd idle", v, 0);
    set_mode(1'b0);
    reg_wr(8'h00, 32'h10);          // R10 ignored in prefetch mode
    repeat (30) @(negedge clk);
    chk("R10 page ignored in prefetch mode", frames - f0, 0);
    reg_wr(8'h00, 32'h55);          // R11
    repeat (30) @(negedge clk);
    reg_rd(8'h00, v); chk("R11 bad code cmd", v, 0);
    chk("R11 bad code no frame", frames - f0, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    int f0;
    set_mode(1'b0);
    set_addr(32'h7E_12_34_FF);
    reg_wr(8'h14, 32'hA5);
    f0 = frames;
    reg_wr(8'h00, 32'h90);
    reg_rd(8'h00, v); chk("R5 pio busy", v, 32'h90);
    wait_idle();
    expb[0] = 8'h02; expb[1] = 8'h12; expb[2] = 8'h34; expb[3] = 8'hFF; expb[4] = 8'hA5;
    cmp_frame("R8 single byte", 5);
    reg_rd(8'h08, v); chk("R9 addr0 incr", v, 32'h00);
    reg_rd(8'h0C, v); chk("R9 addr1 carry", v, 32'h35);
    reg_rd(8'h20, v); chk("R9 addr3 kept", v, 32'h7E);
    reg_wr(8'h14, 32'h5A);
    reg_wr(8'h00, 32'h90);
    wait_idle();
    chk("R8 two frames", frames - f0, 2);
    expb[0] = 8'h02; expb[1] = 8'h12; expb[2] = 8'h35; expb[3] = 8'h00; expb[4] = 8'h5A;
    cmp_frame("R9 next location", 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_addr();
    t_page_overlap();
    t_ptr_reset();
    t_ignored();
    t_single();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule